// File: doc/BRIEF.md
# Compressed Hint Detector and Expander

This block examines one 16-bit compressed RISC-V instruction per transfer. It decides whether the instruction uses one of the reserved hint encodings among the quadrant-1 and quadrant-2 arithmetic and shift forms. A hint is an encoding that an implementation may treat as having no effect. A mode input travels with each instruction and selects how a detected hint is handled. In one mode the hint becomes the full 32-bit computational instruction it literally encodes. In the other mode it becomes the canonical 32-bit no-op. The two modes therefore leave different architectural traces at retirement.

An instruction that is not a hint is not decoded. It leaves the block zero-extended to 32 bits, with a passthrough flag set. The result is held in one output register behind a valid/ready handshake. A parameter selects a 32-bit or 64-bit register width, and this choice changes which shift encodings count as hints.

Top module: `chint_expander`

## Requirements
- R1: An input with bits[1:0]=01, bits[15:13]=000, bit 12=0, bits[11:7] nonzero and bits[6:2]=0 is a hint. In expand mode it becomes ADDI rd,rd,0 (opcode 0010011, funct3 000, rd=rs1=bits[11:7], imm 0).
- R2: An input with bits[1:0]=01, bits[15:13]=010 and bits[11:7]=0 is a hint. In expand mode it becomes ADDI x0,x0,imm, where imm is {bit12,bits[6:2]} sign-extended to 12 bits and placed in bits[31:20].
- R3: An input with bits[1:0]=01, bits[15:13]=011, bits[11:7]=0 and {bit12,bits[6:2]} nonzero is a hint. In expand mode it becomes LUI x0 (opcode 0110111), with that 6-bit value sign-extended to 20 bits in bits[31:12]. When the 6-bit value is zero, the input is not a hint.
- R4: An input with bits[1:0]=10, bits[15:13]=100, bits[11:7]=0 and bits[6:2] nonzero is a hint, whatever the value of bit 12. In expand mode it becomes ADD x0,x0,rs2 (opcode 0110011, funct7 0, rs2=bits[6:2]). The encoding with bits[6:2]=0 is not a hint.
- R5: An input with bits[1:0]=10 and bits[15:13]=000 is a hint when the shift amount {bit12,bits[6:2]} is zero or bits[11:7] is zero. With a 32-bit width the encoding counts only when bit 12 is 0. In expand mode it becomes SLLI rd,rd,shamt (opcode 0010011, funct3 001, shamt in bits[25:20]).
- R6: An input with bits[1:0]=01, bits[6:2]=0 and bits[15:10] equal to 100000 is a hint that becomes SRLI rd,rd,0. With bits[15:10] equal to 100001 it is a hint that becomes SRAI rd,rd,0, with funct7 0100000. In both cases the destination register is 8 plus bits[9:7], and funct3 is 101.
- R7: In no-op mode (`in_expand`=0), every detected hint leaves as 0x00000013 with `out_is_hint`=1 and `out_passthru`=0.
- R8: A non-hint input, including one whose bits[1:0] are 11, leaves as {16'h0000, input} with `out_is_hint`=0 and `out_passthru`=1.
- R9: `in_ready` is high when the register is empty or `out_ready` is high. A transfer happens when `in_valid` and `in_ready` are both high. While `out_valid`=1 and `out_ready`=0, the outputs hold.
- R10: The mode is captured with its instruction. A later change of `in_expand` does not alter a result that is already held.
- R11: A synchronous reset clears `out_valid` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input instruction present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_instr | input | 16 | Compressed instruction |
| in_expand | input | 1 | 1: expand hints; 0: replace hints with no-op |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_instr | output | 32 | Expanded, no-op or zero-extended instruction |
| out_is_hint | output | 1 | Input was a hint encoding |
| out_passthru | output | 1 | Input was passed through unexpanded |

## Verification
Two functions can meet in one cycle: the register drains to the consumer while it also loads a new instruction, possibly carrying a different mode. This is provoked first by holding an expanded hint under backpressure while `in_expand` is flipped. Then `out_ready` is raised in the same cycle that a new no-op-mode hint is offered. The held word must stay the expanded encoding throughout the stall. The word that follows must be 0x00000013, with no empty cycle in between.

// File: rtl/chint_pkg.sv
`timescale 1ns/1ps
package chint_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_ADDI,
        K_LI,
        K_LUI,
        K_ADDX0,
        K_SLLI,
        K_SRLI,
        K_SRAI
    } hint_kind_e;

    typedef struct packed {
        logic [31:0] instr;
        logic        is_hint;
        logic        passthru;
    } out_word_t;

    localparam logic [6:0]  OPC_IMM   = 7'b0010011;
    localparam logic [6:0]  OPC_LUI   = 7'b0110111;
    localparam logic [6:0]  OPC_REG   = 7'b0110011;
    localparam logic [31:0] CANON_NOP = 32'h0000_0013;

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd);
        return {imm, rs1, f3, rd, OPC_IMM};
    endfunction

    function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd);
        return {imm, rd, OPC_LUI};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, OPC_REG};
    endfunction

endpackage

// File: rtl/chint_classify.sv
`timescale 1ns/1ps
module chint_classify
    import chint_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [15:0] c,
    output hint_kind_e  kind
);
    localparam bit IS64 = (XLEN == 64);

    logic [1:0] quad;
    logic [2:0] f3;
    logic [4:0] rd;
    logic [4:0] lo;
    logic [5:0] imm6;
    logic       slli_width_ok;

    assign quad = c[1:0];
    assign f3   = c[15:13];
    assign rd   = c[11:7];
    assign lo   = c[6:2];
    assign imm6 = {c[12], c[6:2]};

    generate
        if (IS64) begin : g_wide
            assign slli_width_ok = 1'b1;
        end else begin : g_narrow
            assign slli_width_ok = ~c[12];
        end
    endgenerate

    always_comb begin
        kind = K_NONE;
        if (quad == 2'b01) begin
            if (f3 == 3'b000 && !c[12] && rd != 5'd0 && lo == 5'd0)
                kind = K_ADDI;
            else if (f3 == 3'b010 && rd == 5'd0)
                kind = K_LI;
            else if (f3 == 3'b011 && rd == 5'd0 && imm6 != 6'd0)
                kind = K_LUI;
            else if (c[15:10] == 6'b100000 && lo == 5'd0)
                kind = K_SRLI;
            else if (c[15:10] == 6'b100001 && lo == 5'd0)
                kind = K_SRAI;
        end else if (quad == 2'b10) begin
            if (f3 == 3'b100 && rd == 5'd0 && lo != 5'd0)
                kind = K_ADDX0;
            else if (f3 == 3'b000 && (imm6 == 6'd0 || rd == 5'd0) && slli_width_ok)
                kind = K_SLLI;
        end
    end
endmodule

// File: rtl/chint_build.sv
`timescale 1ns/1ps
module chint_build
    import chint_pkg::*;
(
    input  logic [15:0] c,
    input  hint_kind_e  kind,
    input  logic        expand,
    output out_word_t   w
);
    logic [4:0]  rd_full;
    logic [4:0]  rd_pr;
    logic [4:0]  rs2;
    logic [5:0]  imm6;
    logic [31:0] expanded;
    logic        hit;

    assign rd_full = c[11:7];
    assign rd_pr   = {2'b01, c[9:7]};
    assign rs2     = c[6:2];
    assign imm6    = {c[12], c[6:2]};
    assign hit     = (kind != K_NONE);

    always_comb begin
        case (kind)
            K_ADDI:  expanded = enc_i(12'd0, rd_full, 3'b000, rd_full);
            K_LI:    expanded = enc_i({{6{imm6[5]}}, imm6}, 5'd0, 3'b000, 5'd0);
            K_LUI:   expanded = enc_u({{14{imm6[5]}}, imm6}, 5'd0);
            K_ADDX0: expanded = enc_r(7'd0, rs2, 5'd0, 3'b000, 5'd0);
            K_SLLI:  expanded = enc_i({6'd0, imm6}, rd_full, 3'b001, rd_full);
            K_SRLI:  expanded = enc_i(12'd0, rd_pr, 3'b101, rd_pr);
            K_SRAI:  expanded = enc_i({7'b0100000, 5'd0}, rd_pr, 3'b101, rd_pr);
            default: expanded = CANON_NOP;
        endcase
    end

    always_comb begin
        w.is_hint  = hit;
        w.passthru = ~hit;
        if (!hit)
            w.instr = {16'h0000, c};
        else if (expand)
            w.instr = expanded;
        else
            w.instr = CANON_NOP;
    end
endmodule

// File: rtl/chint_stage.sv
`timescale 1ns/1ps
module chint_stage
    import chint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    output logic      in_ready,
    input  out_word_t d,
    output logic      out_valid,
    input  logic      out_ready,
    output out_word_t q
);
    logic      valid_q;
    out_word_t data_q;

    assign in_ready  = ~valid_q | out_ready;
    assign out_valid = valid_q;
    assign q         = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (in_ready) begin
            valid_q <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready)
            data_q <= d;
    end

    assert_reset_clears_R11: assert property (@(posedge clk) rst |=> !out_valid);

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(q)));

    assert_empty_ready_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    assert_accept_loads_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/chint_expander.sv
`timescale 1ns/1ps
module chint_expander
    import chint_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_instr,
    input  logic        in_expand,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_instr,
    output logic        out_is_hint,
    output logic        out_passthru
);
    hint_kind_e kind;
    out_word_t  word_d;
    out_word_t  word_q;

    chint_classify #(.XLEN(XLEN)) u_classify (
        .c    (in_instr),
        .kind (kind)
    );

    chint_build u_build (
        .c      (in_instr),
        .kind   (kind),
        .expand (in_expand),
        .w      (word_d)
    );

    chint_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (word_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (word_q)
    );

    assign out_instr    = word_q.instr;
    assign out_is_hint  = word_q.is_hint;
    assign out_passthru = word_q.passthru;

    assert_passthru_zext_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_passthru) |-> (out_instr[31:16] == 16'h0000 && !out_is_hint));

    assert_hint_opcode_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_hint) |->
        (out_instr[6:0] == OPC_IMM || out_instr[6:0] == OPC_LUI || out_instr[6:0] == OPC_REG));
endmodule

// File: tb/chint_expander_tb.sv
`timescale 1ns/1ps
module chint_expander_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_instr;
    logic        in_expand;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_instr;
    logic        out_is_hint;
    logic        out_passthru;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chint_expander #(.XLEN(32)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_expand(in_expand), .out_valid(out_valid),
        .out_ready(out_ready), .out_instr(out_instr), .out_is_hint(out_is_hint),
        .out_passthru(out_passthru)
    );

    typedef struct packed {
        logic [15:0] c;
        logic        ex;
        logic [31:0] w;
        logic        h;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R1 addi hint rd=5
        '{{3'b000,1'b0,5'd5,5'd0,2'b01}, 1'b1, {12'd0,5'd5,3'b000,5'd5,7'h13}, 1'b1},
        // R7 same, no-op mode
        '{{3'b000,1'b0,5'd5,5'd0,2'b01}, 1'b0, 32'h0000_0013, 1'b1},
        // R8 ordinary addi
        '{{3'b000,1'b0,5'd5,5'd3,2'b01}, 1'b1, {16'd0,3'b000,1'b0,5'd5,5'd3,2'b01}, 1'b0},
        // R1 bit12 set, not a hint
        '{{3'b000,1'b1,5'd5,5'd0,2'b01}, 1'b1, {16'd0,3'b000,1'b1,5'd5,5'd0,2'b01}, 1'b0},
        // R2 li hint imm -3
        '{{3'b010,1'b1,5'd0,5'b11101,2'b01}, 1'b1, {12'hFFD,5'd0,3'b000,5'd0,7'h13}, 1'b1},
        // R7 li hint no-op mode
        '{{3'b010,1'b0,5'd0,5'd5,2'b01}, 1'b0, 32'h0000_0013, 1'b1},
        // R3 lui hint imm 100001
        '{{3'b011,1'b1,5'd0,5'b00001,2'b01}, 1'b1, {20'hFFFE1,5'd0,7'h37}, 1'b1},
        // R3 lui rd0 imm0, not a hint
        '{{3'b011,1'b0,5'd0,5'd0,2'b01}, 1'b1, {16'd0,3'b011,1'b0,5'd0,5'd0,2'b01}, 1'b0},
        // R4 mv hint rs2=7
        '{{4'b1000,5'd0,5'd7,2'b10}, 1'b1, {7'd0,5'd7,5'd0,3'b000,5'd0,7'h33}, 1'b1},
        // R4 add hint rs2=31
        '{{4'b1001,5'd0,5'd31,2'b10}, 1'b1, {7'd0,5'd31,5'd0,3'b000,5'd0,7'h33}, 1'b1},
        // R4 rs2=0 form, not a hint
        '{{4'b1001,5'd0,5'd0,2'b10}, 1'b1, {16'd0,4'b1001,5'd0,5'd0,2'b10}, 1'b0},
        // R5 slli shamt 0 rd=9
        '{{3'b000,1'b0,5'd9,5'd0,2'b10}, 1'b1, {7'd0,5'd0,5'd9,3'b001,5'd9,7'h13}, 1'b1},
        // R5 slli rd0 shamt 4
        '{{3'b000,1'b0,5'd0,5'd4,2'b10}, 1'b1, {7'd0,5'd4,5'd0,3'b001,5'd0,7'h13}, 1'b1},
        // R5 shamt bit5 on 32-bit width, not a hint
        '{{3'b000,1'b1,5'd0,5'd4,2'b10}, 1'b1, {16'd0,3'b000,1'b1,5'd0,5'd4,2'b10}, 1'b0},
        // R5 ordinary slli
        '{{3'b000,1'b0,5'd3,5'd2,2'b10}, 1'b1, {16'd0,3'b000,1'b0,5'd3,5'd2,2'b10}, 1'b0},
        // R6 srli hint x10
        '{{6'b100000,3'd2,5'd0,2'b01}, 1'b1, {7'd0,5'd0,5'd10,3'b101,5'd10,7'h13}, 1'b1},
        // R6 srai hint x15
        '{{6'b100001,3'd7,5'd0,2'b01}, 1'b1, {7'h20,5'd0,5'd15,3'b101,5'd15,7'h13}, 1'b1},
        // R7 srai hint no-op mode
        '{{6'b100001,3'd7,5'd0,2'b01}, 1'b0, 32'h0000_0013, 1'b1},
        // R6 srli nonzero shift, not a hint
        '{{6'b100000,3'd2,5'd3,2'b01}, 1'b1, {16'd0,6'b100000,3'd2,5'd3,2'b01}, 1'b0},
        // R8 full-width low bits 11
        '{16'h0093, 1'b1, 32'h0000_0093, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] c, input logic ex);
        @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = c;
        in_expand = ex;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_expand = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R9 reset in_ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk); rst = 1'b0;

        // table walk, R1..R8
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].c, VECS[i].ex);
            chk($sformatf("R1-8 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
            chk($sformatf("R1-8 vec%0d instr", i), out_instr, VECS[i].w);
            chk($sformatf("R1-8 vec%0d hint", i), {31'd0, out_is_hint}, {31'd0, VECS[i].h});
            chk($sformatf("R8 vec%0d passthru", i), {31'd0, out_passthru}, {31'd0, ~VECS[i].h});
        end
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9 drains when idle", {31'd0, out_valid}, 32'd0);

        // R9 / R10 backpressure with a mode change while held
        @(negedge clk); out_ready = 1'b0;
        send({3'b000,1'b0,5'd5,5'd0,2'b01}, 1'b1);
        chk("R9 held valid", {31'd0, out_valid}, 32'd1);
        chk("R9 in_ready low when full", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        in_instr = {6'b100001,3'd7,5'd0,2'b01};
        in_expand = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R10 held word keeps expanded form", out_instr, {12'd0,5'd5,3'b000,5'd5,7'h13});
        chk("R9 still valid under stall", {31'd0, out_valid}, 32'd1);
        @(negedge clk); out_ready = 1'b1;
        @(posedge clk); #1;
        chk("R10 new word uses no-op mode", out_instr, 32'h0000_0013);
        chk("R9 back-to-back valid", {31'd0, out_valid}, 32'd1);

        // R11 reset while holding data
        @(negedge clk); out_ready = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R11 mid-transfer reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk); rst = 1'b0; out_ready = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule